// File: doc/BRIEF.md
# Delay-Slot-Aware Exception Capture Unit

This unit sits beside the execute stage of a simple in-order processor that has branch delay slots. Each cycle it watches the instruction that is retiring: its address, whether it is a control-transfer instruction, whether it is a return-from-exception, and a vector of synchronous fault strobes. When a fault is raised it saves a resume address and the pre-fault status word, moves the live status word into a privileged state, and sends fetch to the fixed handler address of the winning fault. A return-from-exception restores the status word and sends fetch back to the saved address.

The unit notes whether the retiring instruction sits in the slot after a branch or jump. This holds for every branch and jump form, whether or not it is taken. A fault in that slot saves the address of the branch rather than the slot instruction, and sets a delay-slot indicator in the live status word. The handler can then resume at the branch and replay both instructions. The live status word, the saved address and the saved status word can also be read and written through a special-register port.

The fetch redirect is a one-cycle pulse with no back-pressure, and fetch must accept it in the cycle it is shown. All other pins are plain level signals.

Top module: `exc_capture_unit`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, `redirect_valid` is 1 and `redirect_pc` is the reset handler 0x100. Reset also sets the live status word to 0x1 (supervisor bit only) and clears the saved address and the saved status word.
- R2: Fault strobe bits are 0 bus error, 1 data translation miss, 2 misalignment, 3 illegal opcode, 4 trap. With several strobes raised at once, the lowest bit wins. The handler addresses are 0x200, 0x900, 0x600, 0x700 and 0xE00 respectively, and the chosen one appears on `redirect_pc` one cycle after the faulting instruction.
- R3: A fault on an instruction that is not in a delay slot saves its own address, and leaves status bit 13 (delay-slot indicator) at 0.
- R4: A fault on the instruction retiring right after a control-transfer instruction saves the address of that control-transfer instruction, and sets status bit 13. This applies whether the branch was taken or not.
- R5: The delay-slot state starts when a control-transfer instruction retires without a fault. It ends when the next instruction retires. Cycles with `insn_valid` low leave it unchanged. A control-transfer instruction that itself faults, or that is a return-from-exception, opens no slot.
- R6: On a fault, the saved status word gets the live status word from before the fault. In the live status word, bit 0 (supervisor) is set, and bits 2 (interrupt enable), 5 (data translation enable) and 6 (instruction translation enable) are cleared. Bit 13 follows R3/R4 and all other bits are kept.
- R7: A return-from-exception without a fault loads the live status word from the saved status word, and pulses a redirect to the saved address one cycle later.
- R8: Special-register select 0 is the live status word, 1 the saved address, and 2 the saved status word. A write takes effect at the next clock edge. `spr_rdata` shows the selected register in the same cycle.
- R9: A fault beats both a special-register write and a return-from-exception in the same cycle, and both of those are dropped. A return-from-exception beats a write to the live status word, but a write to the saved address in the same cycle still takes effect.
- R10: `redirect_valid` is 1 only in the cycle after a fault or a return-from-exception (apart from R1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction retires or faults this cycle |
| insn_pc | input | W | Address of that instruction |
| insn_is_cti | input | 1 | The instruction is a branch or jump (any form, taken or not) |
| insn_rfe | input | 1 | The instruction is a return-from-exception |
| exc_req | input | 5 | Synchronous fault strobes, bit order per R2 |
| spr_we | input | 1 | Special-register write enable |
| spr_sel | input | 2 | Special-register select per R8 |
| spr_wdata | input | W | Special-register write data |
| spr_rdata | output | W | Selected special register |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | W | Fetch redirect address |
| sr_o | output | W | Live status word |
| epc_o | output | W | Saved resume address |
| esr_o | output | W | Saved status word |

## Verification
Two functions can land in the same cycle. A fault can meet a special-register write, and a return-from-exception can meet a write. Both are provoked by driving the two on the same retiring instruction. The judgement is that the fault's saved values survive and the write vanishes, that a return keeps its restore, and that a write to the saved address still lands. The delay-slot decision is covered by faulting straight after a branch, after a branch followed by bubble cycles, after a branch and one ordinary instruction, and on a branch that itself faults.

// File: rtl/exc_cap_pkg.sv
package exc_cap_pkg;
  localparam int unsigned NUM_EXC = 5;

  // strobe positions, lowest index has highest priority
  localparam int unsigned EXB_BUS   = 0;
  localparam int unsigned EXB_TLB   = 1;
  localparam int unsigned EXB_ALIGN = 2;
  localparam int unsigned EXB_ILL   = 3;
  localparam int unsigned EXB_TRAP  = 4;

  // status word bit positions
  localparam int unsigned SRB_SUPV = 0;
  localparam int unsigned SRB_IEN  = 2;
  localparam int unsigned SRB_DXEN = 5;
  localparam int unsigned SRB_IXEN = 6;
  localparam int unsigned SRB_DSLT = 13;

  localparam logic [1:0] SEL_SR  = 2'd0;
  localparam logic [1:0] SEL_EPC = 2'd1;
  localparam logic [1:0] SEL_ESR = 2'd2;

  localparam logic [15:0] VEC_RESET = 16'h0100;

  function automatic logic [15:0] handler_addr(input int unsigned idx);
    case (idx)
      EXB_BUS:   return 16'h0200;
      EXB_TLB:   return 16'h0900;
      EXB_ALIGN: return 16'h0600;
      EXB_ILL:   return 16'h0700;
      default:   return 16'h0E00;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_cap_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [NUM_EXC-1:0] req,
  output logic               any,
  output logic [W-1:0]       vec
);
  logic [15:0] pick;

  always_comb begin
    pick = handler_addr(EXB_TRAP);
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (req[i]) pick = handler_addr(i);
    end
  end

  assign any = |req;
  assign vec = W'(pick);
endmodule

// File: rtl/ds_tracker.sv
module ds_tracker #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         retire,
  input  logic         is_cti,
  input  logic         flush,
  input  logic [W-1:0] pc,
  output logic         ds_flag,
  output logic [W-1:0] ds_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_flag <= 1'b0;
      ds_pc   <= '0;
    end else if (retire) begin
      ds_flag <= is_cti && !flush;
      if (is_cti && !flush) ds_pc <= pc;
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_cap_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_exc,
  input  logic         take_rfe,
  input  logic         ds_flag,
  input  logic [W-1:0] ds_pc,
  input  logic [W-1:0] insn_pc,
  input  logic         spr_we,
  input  logic [1:0]   spr_sel,
  input  logic [W-1:0] spr_wdata,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] epc_q,
  output logic [W-1:0] esr_q
);
  localparam logic [W-1:0] SR_RESET = W'(1) << SRB_SUPV;

  logic [W-1:0] sr_entry;

  always_comb begin
    sr_entry           = sr_q;
    sr_entry[SRB_SUPV] = 1'b1;
    sr_entry[SRB_IEN]  = 1'b0;
    sr_entry[SRB_DXEN] = 1'b0;
    sr_entry[SRB_IXEN] = 1'b0;
    sr_entry[SRB_DSLT] = ds_flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= SR_RESET;
      epc_q <= '0;
      esr_q <= '0;
    end else if (take_exc) begin
      esr_q <= sr_q;
      epc_q <= ds_flag ? ds_pc : insn_pc;
      sr_q  <= sr_entry;
    end else begin
      if (take_rfe)                          sr_q  <= esr_q;
      else if (spr_we && spr_sel == SEL_SR)  sr_q  <= spr_wdata;
      if (spr_we && spr_sel == SEL_EPC)      epc_q <= spr_wdata;
      if (spr_we && spr_sel == SEL_ESR)      esr_q <= spr_wdata;
    end
  end
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
  import exc_cap_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [W-1:0]       insn_pc,
  input  logic               insn_is_cti,
  input  logic               insn_rfe,
  input  logic [NUM_EXC-1:0] exc_req,
  input  logic               spr_we,
  input  logic [1:0]         spr_sel,
  input  logic [W-1:0]       spr_wdata,
  output logic [W-1:0]       spr_rdata,
  output logic               redirect_valid,
  output logic [W-1:0]       redirect_pc,
  output logic [W-1:0]       sr_o,
  output logic [W-1:0]       epc_o,
  output logic [W-1:0]       esr_o
);
  logic         exc_any;
  logic [W-1:0] exc_vec;
  logic         take_exc;
  logic         take_rfe;
  logic         ds_flag;
  logic [W-1:0] ds_pc;

  exc_prio #(.W(W)) u_prio (
    .req (exc_req),
    .any (exc_any),
    .vec (exc_vec)
  );

  assign take_exc = insn_valid && exc_any;
  assign take_rfe = insn_valid && insn_rfe && !exc_any;

  ds_tracker #(.W(W)) u_ds (
    .clk     (clk),
    .rst_n   (rst_n),
    .retire  (insn_valid),
    .is_cti  (insn_is_cti),
    .flush   (exc_any || insn_rfe),
    .pc      (insn_pc),
    .ds_flag (ds_flag),
    .ds_pc   (ds_pc)
  );

  exc_state #(.W(W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_exc  (take_exc),
    .take_rfe  (take_rfe),
    .ds_flag   (ds_flag),
    .ds_pc     (ds_pc),
    .insn_pc   (insn_pc),
    .spr_we    (spr_we),
    .spr_sel   (spr_sel),
    .spr_wdata (spr_wdata),
    .sr_q      (sr_o),
    .epc_q     (epc_o),
    .esr_q     (esr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= W'(VEC_RESET);
    end else begin
      redirect_valid <= take_exc || take_rfe;
      if (take_exc)      redirect_pc <= exc_vec;
      else if (take_rfe) redirect_pc <= epc_o;
    end
  end

  always_comb begin
    case (spr_sel)
      SEL_SR:  spr_rdata = sr_o;
      SEL_EPC: spr_rdata = epc_o;
      SEL_ESR: spr_rdata = esr_o;
      default: spr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk
  import exc_cap_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_valid,
  input logic [W-1:0]       insn_pc,
  input logic               insn_rfe,
  input logic [NUM_EXC-1:0] exc_req,
  input logic               redirect_valid,
  input logic [W-1:0]       redirect_pc,
  input logic [W-1:0]       sr_o,
  input logic [W-1:0]       epc_o,
  input logic [W-1:0]       esr_o,
  input logic               ds_flag,
  input logic [W-1:0]       ds_pc
);
  logic fault, ret, up;
  assign fault = insn_valid && (exc_req != '0);
  assign ret   = insn_valid && insn_rfe && (exc_req == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  assert_reset_vec_R1: assert property (@(posedge clk)
    !rst_n |=> redirect_valid && redirect_pc == W'(VEC_RESET) && sr_o == W'(1));

  assert_bus_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault && exc_req[EXB_BUS] |=> redirect_valid && redirect_pc == W'(16'h0200));

  assert_trap_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault && exc_req == 5'b10000 |=> redirect_pc == W'(16'h0E00));

  assert_plain_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !ds_flag |=> epc_o == $past(insn_pc) && !sr_o[SRB_DSLT]);

  assert_slot_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault && ds_flag |=> epc_o == $past(ds_pc) && sr_o[SRB_DSLT]);

  assert_status_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> esr_o == $past(sr_o) && sr_o[SRB_SUPV] && !sr_o[SRB_IEN]
              && !sr_o[SRB_DXEN] && !sr_o[SRB_IXEN]);

  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> sr_o == $past(esr_o) && redirect_valid && redirect_pc == $past(epc_o));

  assert_pulse_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up && !$past(fault || ret) |-> !redirect_valid);
endmodule

bind exc_capture_unit exc_capture_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .insn_valid     (insn_valid),
  .insn_pc        (insn_pc),
  .insn_rfe       (insn_rfe),
  .exc_req        (exc_req),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .sr_o           (sr_o),
  .epc_o          (epc_o),
  .esr_o          (esr_o),
  .ds_flag        (ds_flag),
  .ds_pc          (ds_pc)
);

// File: tb/sim_exc_capture_unit.sv
module sim_exc_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_pc = '0;
  logic        insn_is_cti = 1'b0;
  logic        insn_rfe = 1'b0;
  logic [4:0]  exc_req = '0;
  logic        spr_we = 1'b0;
  logic [1:0]  spr_sel = '0;
  logic [31:0] spr_wdata = '0;
  logic [31:0] spr_rdata, redirect_pc, sr_o, epc_o, esr_o;
  logic        redirect_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  exc_capture_unit #(.W(32)) u0 (.*);

  typedef struct {
    logic        rv;
    logic [31:0] rpc, sr, epc, esr;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [31:0] m_sr = 32'h1, m_epc = '0, m_esr = '0, m_dspc = '0;
  logic        m_ds = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input logic [4:0] ex);
    if (ex[0]) return 32'h200;
    if (ex[1]) return 32'h900;
    if (ex[2]) return 32'h600;
    if (ex[3]) return 32'h700;
    return 32'hE00;
  endfunction

  task automatic step(input logic v, input logic [31:0] pc, input logic cti, input logic rfe,
                      input logic [4:0] ex, input logic we, input logic [1:0] sel,
                      input logic [31:0] wd, input string tag);
    exp_t e;
    logic fault, ret;
    logic [31:0] s;
    @(negedge clk);
    insn_valid = v; insn_pc = pc; insn_is_cti = cti; insn_rfe = rfe; exc_req = ex;
    spr_we = we; spr_sel = sel; spr_wdata = wd;
    fault = v && (ex != 0);
    ret   = v && rfe && (ex == 0);
    e.tag = tag; e.rv = fault || ret; e.rpc = 'x;
    if (fault) begin
      s = m_sr; s[0] = 1'b1; s[2] = 1'b0; s[5] = 1'b0; s[6] = 1'b0; s[13] = m_ds;
      m_esr = m_sr; m_epc = m_ds ? m_dspc : pc; m_sr = s; e.rpc = vec_of(ex);
    end else begin
      if (ret) e.rpc = m_epc;
      if (ret) m_sr = m_esr;
      else if (we && sel == 2'd0) m_sr = wd;
      if (we && sel == 2'd1) m_epc = wd;
      if (we && sel == 2'd2) m_esr = wd;
    end
    if (v) begin
      m_ds = cti && !fault && !rfe;
      if (m_ds) m_dspc = pc;
    end
    e.sr = m_sr; e.epc = m_epc; e.esr = m_esr;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp);
    @(negedge clk);
    insn_valid = 0; exc_req = 0; insn_rfe = 0; spr_we = 0; spr_sel = sel;
    #1 check("R8", "spr_rdata", spr_rdata, exp);
  endtask

  // monitor: compare one expected item per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "redirect_valid", {31'b0, redirect_valid}, {31'b0, e.rv});
        if (e.rv) check(e.tag, "redirect_pc", redirect_pc, e.rpc);
        check(e.tag, "sr", sr_o, e.sr);
        check(e.tag, "epc", epc_o, e.epc);
        check(e.tag, "esr", esr_o, e.esr);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "redirect_valid", {31'b0, redirect_valid}, 32'd1);
    check("R1", "redirect_pc", redirect_pc, 32'h100);
    check("R1", "sr", sr_o, 32'h1);
    check("R1", "epc", epc_o, 32'h0);
    check("R1", "esr", esr_o, 32'h0);
    rst_n = 1'b1;
    #1 check("R1", "redirect_valid after release", {31'b0, redirect_valid}, 32'd1);
    idle(2);

    // R8 writes and reads
    step(0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0065, "R8 write sr");
    step(0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_1234, "R8 write esr");
    rd(2'd0, 32'h65);
    rd(2'd2, 32'h1234);

    // R3 plain fault, R6 status save
    step(1, 32'h1000, 0, 0, 5'b00100, 0, 0, 0, "R3 R6 misalign");
    step(1, 32'h600, 0, 1, 0, 0, 0, 0, "R7 return");
    idle(1);

    // R4 fault directly after a branch
    step(1, 32'h2000, 1, 0, 0, 0, 0, 0, "R4 branch");
    step(1, 32'h2004, 0, 0, 5'b01000, 0, 0, 0, "R4 slot illegal");
    step(1, 32'h700, 0, 1, 0, 0, 0, 0, "R7 return to branch");

    // R5 bubbles keep the slot
    step(1, 32'h3000, 1, 0, 0, 0, 0, 0, "R5 jump");
    idle(3);
    step(1, 32'h3004, 0, 0, 5'b00001, 0, 0, 0, "R5 slot after bubbles");

    // R5 slot ends after one instruction
    step(1, 32'h4000, 1, 0, 0, 0, 0, 0, "R5 branch");
    step(1, 32'h4004, 0, 0, 0, 0, 0, 0, "R5 slot ok");
    step(1, 32'h4008, 0, 0, 5'b10000, 0, 0, 0, "R5 after slot trap");

    // R5 faulting branch opens no slot
    step(1, 32'h6000, 1, 0, 5'b00010, 0, 0, 0, "R5 faulting branch");
    step(1, 32'h6004, 0, 0, 5'b00100, 0, 0, 0, "R5 no slot after fault");

    // R2 priority
    step(1, 32'h7000, 0, 0, 5'b11111, 0, 0, 0, "R2 all");
    step(1, 32'h7004, 0, 0, 5'b11110, 0, 0, 0, "R2 tlb");
    step(1, 32'h7008, 0, 0, 5'b11100, 0, 0, 0, "R2 align");
    step(1, 32'h700C, 0, 0, 5'b11000, 0, 0, 0, "R2 illegal");
    step(1, 32'h7010, 0, 0, 5'b10000, 0, 0, 0, "R2 trap");

    // R9 collisions
    step(1, 32'h8000, 0, 0, 5'b00100, 1, 2'd1, 32'hDEAD0, "R9 fault vs write");
    step(1, 32'h8004, 0, 1, 5'b10000, 0, 0, 0, "R9 fault vs return");
    step(0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_0045, "R9 set esr");
    step(1, 32'hE00, 0, 1, 0, 1, 2'd0, 32'hFFFF, "R9 return vs sr write");
    step(1, 32'h8010, 0, 1, 0, 1, 2'd1, 32'h5550, "R9 return vs epc write");
    idle(1);
    rd(2'd1, 32'h5550);
    rd(2'd0, 32'h45);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule